// File: doc/BRIEF.md
# SD Host Wrapper Register Bank

This block is a small memory-mapped register bank that sits in front of a standard SD host slot controller. It decodes a 4 KiB window on a simple 32-bit register bus. Word offsets below 0x200 select host-specific registers inside the bank. Accesses at 0x200 and above are handed to a separate slot-register port with the base removed, and the bus waits until that port answers.

Most host registers are plain read/write words. Three of them act on a write. The information word at offset 0x00 cannot be written, but setting its bit 0 restores the whole bank to its reset contents and sends a one-clock reset pulse to the slot controller. The PHY access word at 0x10 stores an acknowledge flag that shows whether the written value requested a PHY read or write. The eMMC control word at 0x18 never keeps its tuning-request bit.

A requester holds `bus_req` and the access fields steady until it sees a one-cycle `bus_ack`. It samples `bus_rdata` and `bus_err` in that cycle and may drop the request in the cycle that follows.

Top module: `sdh_wrap_regbank`

## Requirements
- R1: After `rst`, every host word reads 0, except offset 0x00, which reads 0x00010000.
- R2: An access whose `bus_size` is not 2'b10 (full word), or whose `bus_addr[1:0]` is not 0, completes with `bus_ack` and `bus_err` high and `bus_rdata` equal to 0. It changes no host word and starts no slot access.
- R3: A write to offset 0x00 with bit 0 clear leaves that word at 0x00010000 and causes no reset.
- R4: A word-sized write to offset 0x00 with bit 0 set completes without error. Once it completes, every host word is back at its R1 value.
- R5: `slot_rst` is high for exactly one clock after each software reset of R4. It stays low at all other times, including during and after `rst`.
- R6: A write to offset 0x10 stores the written value, except that bit 26 is stored as 1 when bit 24 or bit 25 of the written value is 1, and as 0 otherwise.
- R7: A write to offset 0x18 stores the written value with bit 15 forced to 0.
- R8: A write to any other host offset from 0x04 to 0x1FC stores the 32-bit value unchanged, and a read returns it.
- R9: An aligned word access at offset 0x200 or above raises `slot_req`, with `slot_addr` equal to `bus_addr` minus 0x200, and with `slot_we` and `slot_wdata` taken from the request. No host word changes.
- R10: `slot_req` and its fields stay fixed until `slot_ready` is high. `bus_ack` follows in the next cycle and returns `slot_rdata` for a read, and `slot_req` is low in that cycle.
- R11: `bus_ack` is a one-cycle pulse. For a host or rejected access it comes in the first clock after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Error response, valid with bus_ack |
| slot_req | output | 1 | Slot-port request, held until slot_ready |
| slot_we | output | 1 | Slot-port write enable |
| slot_addr | output | 12 | Offset relative to 0x200 |
| slot_wdata | output | 32 | Slot-port write data |
| slot_rdata | input | 32 | Slot-port read data, valid with slot_ready |
| slot_ready | input | 1 | Slot-port completion |
| slot_rst | output | 1 | One-clock reset pulse to the slot controller |

## Verification
The assertions check, on every cycle, the handshake properties. `bus_ack` lasts one cycle. An error always comes with an acknowledge and zero data. A slot request stays stable until it is ready and is then followed by an acknowledge. A `slot_rst` pulse lasts one clock and only follows a software-reset write. Stored values are a different matter. The masking of bit 26 and bit 15, the protection of the information word, the clearing of the bank by software reset, and the data passed through the slot port can only be shown by the bench's directed write and readback sequences.

// File: rtl/sdh_wrap_pkg.sv
package sdh_wrap_pkg;
  localparam logic [1:0]  SZ_WORD  = 2'b10;
  localparam logic [31:0] INFO_RST = 32'h0001_0000;
  localparam int IDX_INFO  = 0;
  localparam int IDX_PHY   = 4;
  localparam int IDX_EMMC  = 6;
  localparam int SWR_BIT   = 0;
  localparam int PHY_WREQ  = 24;
  localparam int PHY_RREQ  = 25;
  localparam int PHY_ACK   = 26;
  localparam int TUNE_BIT  = 15;

  typedef enum logic [1:0] {ST_IDLE, ST_SLOT, ST_DONE} bus_state_e;
endpackage

// File: rtl/sdh_addr_decode.sv
module sdh_addr_decode
  import sdh_wrap_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SLOT_BASE = 'h200,
  parameter int IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              bad,
  output logic              slot_sel,
  output logic [IDX_W-1:0]  host_idx,
  output logic [ADDR_W-1:0] slot_off
);
  always_comb begin
    bad      = (size != SZ_WORD) || (addr[1:0] != 2'b00);
    slot_sel = (addr >= ADDR_W'(SLOT_BASE));
    host_idx = addr[IDX_W+1:2];
    slot_off = addr - ADDR_W'(SLOT_BASE);
  end
endmodule

// File: rtl/sdh_host_regs.sv
module sdh_host_regs
  import sdh_wrap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWORDS = 128,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              swr_hit
);
  logic [DATA_W-1:0] regs [NWORDS];
  logic [DATA_W-1:0] shaped;

  // Write-side shaping: side effects are applied before storage
  always_comb begin
    shaped = wr_data;
    if (idx == IDX_W'(IDX_PHY))
      shaped[PHY_ACK] = wr_data[PHY_WREQ] | wr_data[PHY_RREQ];
    if (idx == IDX_W'(IDX_EMMC))
      shaped[TUNE_BIT] = 1'b0;
  end

  assign swr_hit = wr_en && (idx == IDX_W'(IDX_INFO)) && wr_data[SWR_BIT];
  assign rd_data = regs[idx];

  always_ff @(posedge clk) begin
    if (rst || swr_hit) begin
      for (int i = 0; i < NWORDS; i++)
        regs[i] <= (i == IDX_INFO) ? DATA_W'(INFO_RST) : '0;
    end else if (wr_en && (idx != IDX_W'(IDX_INFO))) begin
      regs[idx] <= shaped;
    end
  end
endmodule

// File: rtl/sdh_slot_link.sv
module sdh_slot_link #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_off,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              slot_ready,
  output logic              slot_req,
  output logic              slot_we,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [DATA_W-1:0] slot_wdata,
  output logic              done
);
  assign done = slot_req && slot_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_req   <= 1'b0;
      slot_we    <= 1'b0;
      slot_addr  <= '0;
      slot_wdata <= '0;
    end else if (start) begin
      slot_req   <= 1'b1;
      slot_we    <= start_we;
      slot_addr  <= start_off;
      slot_wdata <= start_wdata;
    end else if (done) begin
      slot_req   <= 1'b0;
    end
  end
endmodule

// File: rtl/sdh_wrap_regbank.sv
module sdh_wrap_regbank
  import sdh_wrap_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int SLOT_BASE = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic              slot_req,
  output logic              slot_we,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [DATA_W-1:0] slot_wdata,
  input  logic [DATA_W-1:0] slot_rdata,
  input  logic              slot_ready,
  output logic              slot_rst
);
  localparam int NWORDS = SLOT_BASE / 4;
  localparam int IDX_W  = $clog2(NWORDS);

  bus_state_e        state;
  logic              bad, slot_sel, accept, host_wr, slot_start, slot_done, swr_hit;
  logic [IDX_W-1:0]  host_idx;
  logic [ADDR_W-1:0] slot_off;
  logic [DATA_W-1:0] host_rd;

  sdh_addr_decode #(.ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .bad(bad), .slot_sel(slot_sel),
    .host_idx(host_idx), .slot_off(slot_off)
  );

  assign accept     = (state == ST_IDLE) && bus_req;
  assign host_wr    = accept && !bad && !slot_sel && bus_we;
  assign slot_start = accept && !bad && slot_sel;

  sdh_host_regs #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(host_wr), .idx(host_idx),
    .wr_data(bus_wdata), .rd_data(host_rd), .swr_hit(swr_hit)
  );

  sdh_slot_link #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst(rst), .start(slot_start), .start_we(bus_we),
    .start_off(slot_off), .start_wdata(bus_wdata), .slot_ready(slot_ready),
    .slot_req(slot_req), .slot_we(slot_we), .slot_addr(slot_addr),
    .slot_wdata(slot_wdata), .done(slot_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
      slot_rst  <= 1'b0;
    end else begin
      slot_rst <= swr_hit;
      bus_ack  <= 1'b0;
      bus_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (bus_req) begin
            if (bad) begin
              bus_ack   <= 1'b1;
              bus_err   <= 1'b1;
              bus_rdata <= '0;
              state     <= ST_DONE;
            end else if (slot_sel) begin
              state     <= ST_SLOT;
            end else begin
              bus_ack   <= 1'b1;
              bus_rdata <= bus_we ? '0 : host_rd;
              state     <= ST_DONE;
            end
          end
        end
        ST_SLOT: begin
          if (slot_done) begin
            bus_ack   <= 1'b1;
            bus_rdata <= slot_we ? '0 : slot_rdata;
            state     <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdh_wrap_regbank_chk.sv
module sdh_wrap_regbank_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int SLOT_BASE = 'h200
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              slot_req,
  input logic              slot_ready,
  input logic [ADDR_W-1:0] slot_addr,
  input logic              slot_rst
);
  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R2
  err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_ack && (bus_rdata == '0)));

  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_ready) |=> (slot_req && $stable(slot_addr)));

  // R10
  slot_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_ready) |=> (bus_ack && !slot_req));

  // R9
  slot_offset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_req) |-> ($past(bus_req && (bus_addr >= ADDR_W'(SLOT_BASE)))
                         && (slot_addr == $past(bus_addr) - ADDR_W'(SLOT_BASE))));

  // R5
  rst_pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    slot_rst |=> !slot_rst);

  // R5
  rst_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    slot_rst |-> $past(bus_req && bus_we && (bus_addr == '0) && (bus_size == 2'b10)
                       && bus_wdata[0]));
endmodule

bind sdh_wrap_regbank sdh_wrap_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_ack(bus_ack), .bus_err(bus_err), .slot_req(slot_req),
  .slot_ready(slot_ready), .slot_addr(slot_addr), .slot_rst(slot_rst)
);

// File: tb/sdh_wrap_regbank_tb.sv
`timescale 1ns/1ps
module sdh_wrap_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = 2'b10;
  logic [31:0] wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;
  logic        slot_req, slot_we, slot_rst;
  logic [11:0] slot_addr;
  logic [31:0] slot_wdata;
  logic [31:0] slot_rdata = '0;
  logic        slot_ready = 1'b0;

  int nchk = 0, nfail = 0;
  int lat = 1, cnt = 0, slot_hits = 0, rst_pulses = 0;
  logic [11:0] last_off;
  logic        last_we;
  logic [31:0] smem [16];

  always #10 clk = ~clk;

  sdh_wrap_regbank u_dut (
    .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .slot_req(slot_req),
    .slot_we(slot_we), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
    .slot_rdata(slot_rdata), .slot_ready(slot_ready), .slot_rst(slot_rst)
  );

  // Slot controller model: answers after lat cycles
  always @(negedge clk) begin
    if (slot_rst) rst_pulses++;
    if (!slot_req) begin
      slot_ready = 1'b0;
      cnt = 0;
    end else if (!slot_ready) begin
      cnt++;
      if (cnt >= lat) begin
        slot_ready = 1'b1;
        slot_hits++;
        last_off = slot_addr;
        last_we  = slot_we;
        if (slot_we) smem[slot_addr[5:2]] = slot_wdata;
        slot_rdata = smem[slot_addr[5:2]];
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] d, output logic [31:0] rd,
                      output logic e, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_ack && cyc < 50);
    rd = bus_rdata; e = bus_err; req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; logic e; int c;
    xfer(1'b1, a, 2'b10, d, rd, e, c);
  endtask

  task automatic rd_chk(input string r, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic e; int c;
    xfer(1'b0, a, 2'b10, '0, rd, e, c);
    chk(r, rd, exp);
  endtask

  task automatic t_reset;
    logic [31:0] rd; logic e; int c;
    xfer(1'b0, 12'h000, 2'b10, '0, rd, e, c);
    chk("R1 info reset", rd, 32'h0001_0000);
    chk("R11 host latency", c, 1);
    @(negedge clk);
    chk("R11 ack one cycle", {31'b0, bus_ack}, 0);
    rd_chk("R1 phy reset", 12'h010, 0);
    rd_chk("R1 emmc reset", 12'h018, 0);
    rd_chk("R1 top host reset", 12'h1FC, 0);
    chk("R5 no pulse on rst", rst_pulses, 0);
  endtask

  task automatic t_info;
    wr(12'h000, 32'hFFFF_FFFE);
    rd_chk("R3 info read-only", 12'h000, 32'h0001_0000);
    chk("R5 no pulse without bit0", rst_pulses, 0);
  endtask

  task automatic t_phy;
    wr(12'h010, 32'h0100_1234); rd_chk("R6 wreq sets ack", 12'h010, 32'h0500_1234);
    wr(12'h010, 32'h0200_0000); rd_chk("R6 rreq sets ack", 12'h010, 32'h0600_0000);
    wr(12'h010, 32'h0400_00FF); rd_chk("R6 no req clears ack", 12'h010, 32'h0000_00FF);
    wr(12'h010, 32'h0700_0000); rd_chk("R6 both reqs", 12'h010, 32'h0700_0000);
  endtask

  task automatic t_tune;
    wr(12'h018, 32'h0000_FFFF); rd_chk("R7 tune bit cleared", 12'h018, 32'h0000_7FFF);
    wr(12'h018, 32'hA5A5_0000); rd_chk("R7 other bits kept", 12'h018, 32'hA5A5_0000);
  endtask

  task automatic t_plain;
    wr(12'h004, 32'hDEAD_BEEF);
    wr(12'h1FC, 32'h1234_5678);
    wr(12'h014, 32'hFFFF_FFFF);
    rd_chk("R8 plain 0x04", 12'h004, 32'hDEAD_BEEF);
    rd_chk("R8 plain 0x1FC", 12'h1FC, 32'h1234_5678);
    rd_chk("R8 plain 0x14", 12'h014, 32'hFFFF_FFFF);
  endtask

  task automatic t_err;
    logic [31:0] rd; logic e; int c; int hits0;
    hits0 = slot_hits;
    xfer(1'b1, 12'h004, 2'b01, 32'h1111_1111, rd, e, c);
    chk("R2 size error flag", {31'b0, e}, 1);
    chk("R11 error latency", c, 1);
    rd_chk("R2 size error no write", 12'h004, 32'hDEAD_BEEF);
    xfer(1'b1, 12'h006, 2'b10, 32'h2222_2222, rd, e, c);
    chk("R2 misaligned error flag", {31'b0, e}, 1);
    rd_chk("R2 misaligned no write", 12'h004, 32'hDEAD_BEEF);
    xfer(1'b0, 12'h202, 2'b10, '0, rd, e, c);
    chk("R2 misaligned slot error", {31'b0, e}, 1);
    chk("R2 error data zero", rd, 0);
    chk("R2 no slot access", slot_hits, hits0);
  endtask

  task automatic t_slot;
    logic [31:0] rd; logic e; int c;
    lat = 1;
    xfer(1'b1, 12'h234, 2'b10, 32'hCAFE_F00D, rd, e, c);
    chk("R9 slot write ok", {31'b0, e}, 0);
    chk("R9 slot offset", {20'b0, last_off}, 32'h034);
    chk("R9 slot we", {31'b0, last_we}, 1);
    chk("R10 latency lat1", c, 2);
    lat = 3;
    xfer(1'b0, 12'h234, 2'b10, '0, rd, e, c);
    chk("R10 slot read data", rd, 32'hCAFE_F00D);
    chk("R10 latency lat3", c, 4);
    chk("R9 read we", {31'b0, last_we}, 0);
    lat = 2;
    xfer(1'b0, 12'h200, 2'b10, '0, rd, e, c);
    chk("R9 base offset", {20'b0, last_off}, 0);
    chk("R10 base data", rd, 32'h600D_0000);
    xfer(1'b0, 12'hFFC, 2'b10, '0, rd, e, c);
    chk("R9 top offset", {20'b0, last_off}, 32'hDFC);
    chk("R10 top data", rd, 32'h600D_000F);
    rd_chk("R9 host untouched", 12'h004, 32'hDEAD_BEEF);
  endtask

  task automatic t_swr;
    logic [31:0] rd; logic e; int c;
    xfer(1'b1, 12'h000, 2'b10, 32'h0000_0001, rd, e, c);
    chk("R4 swr no error", {31'b0, e}, 0);
    @(negedge clk);
    chk("R5 one pulse", rst_pulses, 1);
    rd_chk("R4 cleared 0x04", 12'h004, 0);
    rd_chk("R4 cleared 0x10", 12'h010, 0);
    rd_chk("R4 cleared 0x1FC", 12'h1FC, 0);
    rd_chk("R4 info restored", 12'h000, 32'h0001_0000);
    chk("R5 still one pulse", rst_pulses, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) smem[i] = 32'h600D_0000 | i;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_info();
    t_phy();
    t_tune();
    t_plain();
    t_err();
    t_slot();
    t_swr();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule